// File: doc/BRIEF.md
# Stereo Audio Level Converter

This block is a digital gain stage for a 16-bit stereo sample stream. It sits after sample recovery and before any oversampling or output formatting. Each strobed left/right pair is scaled by a gain taken from a 128-position ladder with steps of about 0.07 dB. The top position is unity. Position zero is silence.

Pulsed commands start a soft mute, which ramps down to zero, or a return to full scale, which ramps up to unity. Held fade-up and fade-down levels walk the gain one position per sample. A level input adds a fixed −12 dB cut. A mono selector routes one channel to both outputs.

Alongside the gain path, two per-channel peak meters keep the highest input magnitude until they are cleared. A silence timer drives an active-low kill output, which also goes low during mute and in data-disc mode.

Top module: `level_conv`

## Requirements
- R1: After reset the gain position is 127 (unity), out_vld is 0, out_l/out_r are 0, both peaks are 0 and kill_n is 1.
- R2: The coefficient for position k is 0 at k=0. For k>0 it starts at c=32768 and applies, 127−k times, c=(c*32505+16384)>>15. An output sample is round-half-up of (x*c)/2^15, saturated to 16 bits signed, using the gain position held before that strobe.
- R3: out_vld is high for exactly the one cycle after each smp_vld cycle. out_l/out_r are updated only then and hold otherwise.
- R4: A mute_cmd pulse starts a ramp that lowers the position by one at each strobe until it reaches 0. From unity this takes 127 strobes, after which outputs are 0.
- R5: A full_cmd pulse ends mute and raises the position by one per strobe until it reaches 127. If both commands arrive in the same cycle, mute wins. A command takes effect from the next strobe.
- R6: With no ramp running and mute inactive, a held fade_up (without fade_dn) raises the position by one per strobe and saturates at 127. A held fade_dn (without fade_up) lowers it by one per strobe and saturates at 0. Fade inputs are ignored during a ramp, while muted, or when both are high.
- R7: With atten_en high at a strobe, the divisor in R2 becomes 2^17 (−12 dB).
- R8: mono_sel=1 sends the left input to both outputs and mono_sel=2 sends the right input to both. Values 0 and 3 keep stereo.
- R9: Each peak output holds bits [14:7] of the largest magnitude min(|x|,32767) seen on that channel's raw input since the last clear.
- R10: peak_clr high at an edge sets both peaks to 0. A sample strobed in that same cycle is not recorded.
- R11: kill_n goes low one cycle after SIL_TERM = FS_HZ/4 consecutive strobes with both inputs zero. Any strobe with a non-zero input restarts the count.
- R12: kill_n is low one cycle after any cycle in which mute is active or cdrom_mode is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| mute_cmd | input | 1 | Pulse: start soft mute |
| full_cmd | input | 1 | Pulse: ramp back to unity |
| fade_up | input | 1 | Held: step gain up |
| fade_dn | input | 1 | Held: step gain down |
| atten_en | input | 1 | Apply −12 dB |
| mono_sel | input | 2 | 0/3 stereo, 1 left on both, 2 right on both |
| cdrom_mode | input | 1 | Data-disc mode, forces kill |
| peak_clr | input | 1 | Clear both peak meters |
| out_vld | output | 1 | Output sample strobe |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |
| peak_l | output | 8 | Left peak, 8 MSBs of magnitude |
| peak_r | output | 8 | Right peak, 8 MSBs of magnitude |
| kill_n | output | 1 | Active-low kill |

## Verification
Pseudo-random stereo pairs at unity gain separate the rounding and coefficient arithmetic from routing. The same pairs with −12 dB and with each mono setting show whether the shift and the channel swap are applied on the right sample. Long runs of mute, full-scale ramps and held fades walk the gain across all 128 positions and hit both saturation ends, so an off-by-one in the ramp stop or the fade clamp shows up as a mismatched sample. Full-scale and most-negative inputs exercise the peak magnitude clamp. Stretches of exact zeros around the silence threshold, broken by single non-zero samples, show the kill timing to the cycle.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {RAMP_IDLE = 2'd0, RAMP_DOWN = 2'd1, RAMP_UP = 2'd2} ramp_e;

  // ratio of one ladder step (about -0.07 dB) in Q15
  localparam longint unsigned STEP_MUL = 64'd32505;

  function automatic longint unsigned coef_at(input int unsigned k, input int unsigned top,
                                               input int unsigned frac);
    longint unsigned c;
    if (k == 0) return 64'd0;
    c = 64'd1 << frac;
    for (int unsigned i = k; i < top; i++)
      c = (c * STEP_MUL + (64'd1 << (frac - 1))) >> frac;
    return c;
  endfunction
endpackage

// File: rtl/lvl_gain_ctrl.sv
module lvl_gain_ctrl #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             mute_cmd,
  input  logic             full_cmd,
  input  logic             fade_up,
  input  logic             fade_dn,
  output logic [POS_W-1:0] pos,
  output logic             mute_act
);
  import lvl_pkg::*;
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

  ramp_e            ramp, ramp_n;
  logic [POS_W-1:0] pos_n;
  logic             mute_n;

  always_comb begin
    pos_n  = pos;
    ramp_n = ramp;
    mute_n = mute_act;
    if (step_en) begin
      case (ramp)
        RAMP_DOWN: begin
          if (pos != '0) pos_n = pos - 1'b1;
          if (pos_n == '0) ramp_n = RAMP_IDLE;
        end
        RAMP_UP: begin
          if (pos != TOP) pos_n = pos + 1'b1;
          if (pos_n == TOP) ramp_n = RAMP_IDLE;
        end
        default: begin
          if (!mute_act) begin
            if (fade_up && !fade_dn && pos != TOP) pos_n = pos + 1'b1;
            else if (fade_dn && !fade_up && pos != '0) pos_n = pos - 1'b1;
          end
        end
      endcase
    end
    if (mute_cmd) begin
      ramp_n = RAMP_DOWN;
      mute_n = 1'b1;
    end else if (full_cmd) begin
      ramp_n = RAMP_UP;
      mute_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= TOP;
      ramp     <= RAMP_IDLE;
      mute_act <= 1'b0;
    end else begin
      pos      <= pos_n;
      ramp     <= ramp_n;
      mute_act <= mute_n;
    end
  end

  AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pos != $past(pos)) |-> $past(step_en)); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pos == $past(pos) || pos == $past(pos) + 1'b1 || pos == $past(pos) - 1'b1)); // R4
  AST_MUTE_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (mute_act && ramp == RAMP_IDLE) |-> pos == '0); // R4
endmodule

// File: rtl/lvl_scaler.sv
module lvl_scaler #(
  parameter int DW    = 16,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0]     pos,
  input  logic                 atten,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam int NPOS   = 2 ** POS_W;
  localparam int FRAC   = DW - 1;
  localparam int COEF_W = DW + 1;
  localparam int PRW    = DW + COEF_W + 1;
  localparam int ATT_SH = 2;
  localparam logic signed [PRW-1:0] YMAX = PRW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PRW-1:0] YMIN = -PRW'(64'sd1 <<< (DW - 1));

  logic [COEF_W-1:0] rom [NPOS];

  for (genvar k = 0; k < NPOS; k++) begin : g_rom
    assign rom[k] = COEF_W'(lvl_pkg::coef_at(k, NPOS - 1, FRAC));
  end

  logic signed [PRW-1:0] prod, rnd, shf;
  int unsigned sh;

  always_comb begin
    sh   = atten ? FRAC + ATT_SH : FRAC;
    prod = PRW'(x) * $signed({1'b0, rom[pos]});
    rnd  = prod + (PRW'(1) <<< (sh - 1));
    shf  = rnd >>> sh;
    if (shf > YMAX)      y = YMAX[DW-1:0];
    else if (shf < YMIN) y = YMIN[DW-1:0];
    else                 y = shf[DW-1:0];
  end
endmodule

// File: rtl/lvl_peak.sv
module lvl_peak #(
  parameter int DW = 16,
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 vld,
  input  logic signed [DW-1:0] x,
  output logic [PW-1:0]        pk
);
  logic [DW-1:0] mag;
  logic [PW-1:0] top;

  always_comb begin
    if (x == {1'b1, {(DW-1){1'b0}}}) mag = {1'b0, {(DW-1){1'b1}}};
    else if (x[DW-1])                mag = DW'(-x);
    else                             mag = DW'(x);
    top = mag[DW-2 -: PW];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)             pk <= '0;
    else if (vld && top > pk)   pk <= top;
  end

  AST_PEAK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr)) |-> pk == '0); // R10
  AST_PEAK_RISES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr)) |-> pk >= $past(pk)); // R9
endmodule

// File: rtl/lvl_silence.sv
module lvl_silence #(
  parameter int TERM = 11025
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic quiet,
  output logic done
);
  localparam int CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] LIM = CW'(TERM);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (vld) begin
      if (!quiet)      cnt <= '0;
      else if (!done)  cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LIM);

  AST_SIL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld) && !$past(quiet)) |-> cnt == '0); // R11
endmodule

// File: rtl/level_conv.sv
module level_conv #(
  parameter int DW    = 16,
  parameter int PW    = 8,
  parameter int POS_W = 7,
  parameter int FS_HZ = 44100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  input  logic          mute_cmd,
  input  logic          full_cmd,
  input  logic          fade_up,
  input  logic          fade_dn,
  input  logic          atten_en,
  input  logic [1:0]    mono_sel,
  input  logic          cdrom_mode,
  input  logic          peak_clr,
  output logic          out_vld,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic [PW-1:0] peak_l,
  output logic [PW-1:0] peak_r,
  output logic          kill_n
);
  localparam int NCH      = 2;
  localparam int SIL_TERM = FS_HZ / 4;

  logic [POS_W-1:0]     pos;
  logic                 mute_act, sil_done;
  logic signed [DW-1:0] raw [NCH];
  logic signed [DW-1:0] src [NCH];
  logic signed [DW-1:0] scl [NCH];
  logic [PW-1:0]        pk  [NCH];

  assign raw[0] = in_l;
  assign raw[1] = in_r;

  always_comb begin
    case (mono_sel)
      2'd1:    begin src[0] = raw[0]; src[1] = raw[0]; end
      2'd2:    begin src[0] = raw[1]; src[1] = raw[1]; end
      default: begin src[0] = raw[0]; src[1] = raw[1]; end
    endcase
  end

  lvl_gain_ctrl #(.POS_W(POS_W)) u_gain (
    .clk(clk), .rst(rst), .step_en(smp_vld), .mute_cmd(mute_cmd), .full_cmd(full_cmd),
    .fade_up(fade_up), .fade_dn(fade_dn), .pos(pos), .mute_act(mute_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lvl_scaler #(.DW(DW), .POS_W(POS_W)) u_scl (
      .pos(pos), .atten(atten_en), .x(src[c]), .y(scl[c])
    );
    lvl_peak #(.DW(DW), .PW(PW)) u_pk (
      .clk(clk), .rst(rst), .clr(peak_clr), .vld(smp_vld), .x(raw[c]), .pk(pk[c])
    );
  end

  lvl_silence #(.TERM(SIL_TERM)) u_sil (
    .clk(clk), .rst(rst), .vld(smp_vld), .quiet(in_l == '0 && in_r == '0), .done(sil_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
      kill_n  <= 1'b1;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        out_l <= scl[0];
        out_r <= scl[1];
      end
      kill_n <= ~(mute_act | cdrom_mode | sil_done);
    end
  end

  assign peak_l = pk[0];
  assign peak_r = pk[1];

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_vld == $past(smp_vld)); // R3
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smp_vld) && $past(pos) == '0) |-> (out_l == '0 && out_r == '0)); // R4
  AST_KILL_FORCED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cdrom_mode) || $past(mute_act))) |-> !kill_n); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(smp_vld)) |-> ($stable(out_l) && $stable(out_r))); // R3
endmodule

// File: tb/tb_level_conv.sv
module tb_level_conv;
  localparam int CLK_PERIOD = 10;
  localparam int FS   = 400;
  localparam int TERM = FS / 4;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_vld = 0, mute_cmd = 0, full_cmd = 0, fade_up = 0, fade_dn = 0;
  logic atten_en = 0, cdrom_mode = 0, peak_clr = 0;
  logic [1:0] mono_sel = 2'd0;
  logic [15:0] in_l = 0, in_r = 0;
  logic out_vld, kill_n;
  logic [15:0] out_l, out_r;
  logic [7:0] peak_l, peak_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  level_conv #(.FS_HZ(FS)) dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .in_l(in_l), .in_r(in_r),
    .mute_cmd(mute_cmd), .full_cmd(full_cmd), .fade_up(fade_up), .fade_dn(fade_dn),
    .atten_en(atten_en), .mono_sel(mono_sel), .cdrom_mode(cdrom_mode), .peak_clr(peak_clr),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r), .peak_l(peak_l), .peak_r(peak_r),
    .kill_n(kill_n)
  );

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  longint coefs [128];
  initial begin
    for (int k = 0; k < 128; k++) begin
      longint c;
      c = 32768;
      for (int i = k; i < 127; i++) c = (c * 32505 + 16384) >> 15;
      coefs[k] = (k == 0) ? 0 : c;
    end
  end

  function automatic int scale(int x, int pos, bit att);
    longint p, r; int sh;
    sh = att ? 17 : 15;
    p = longint'(x) * coefs[pos];
    r = (p + (longint'(1) << (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int pk8(int x);
    int m;
    m = (x < 0) ? -x : x;
    if (m > 32767) m = 32767;
    return (m >> 7) & 255;
  endfunction

  // reference model
  int m_pos, m_ramp, m_sil, m_ol, m_or, m_pl, m_pr;
  bit m_mute, m_vld, m_kill;
  always @(posedge clk) begin
    if (rst) begin
      m_pos = 127; m_ramp = 0; m_mute = 0; m_ol = 0; m_or = 0; m_vld = 0;
      m_pl = 0; m_pr = 0; m_sil = 0; m_kill = 1;
    end else begin
      bit kn; int a, b, xl, xr;
      kn = !(m_mute || cdrom_mode || m_sil == TERM);
      xl = int'($signed(in_l)); xr = int'($signed(in_r));
      m_vld = smp_vld;
      if (smp_vld) begin
        a = (mono_sel == 2) ? xr : xl;
        b = (mono_sel == 1) ? xl : xr;
        m_ol = scale(a, m_pos, atten_en);
        m_or = scale(b, m_pos, atten_en);
        if (xl == 0 && xr == 0) begin if (m_sil < TERM) m_sil++; end
        else m_sil = 0;
      end
      if (peak_clr) begin m_pl = 0; m_pr = 0; end
      else if (smp_vld) begin
        if (pk8(xl) > m_pl) m_pl = pk8(xl);
        if (pk8(xr) > m_pr) m_pr = pk8(xr);
      end
      if (smp_vld) begin
        if (m_ramp == 1) begin if (m_pos > 0) m_pos--; if (m_pos == 0) m_ramp = 0; end
        else if (m_ramp == 2) begin if (m_pos < 127) m_pos++; if (m_pos == 127) m_ramp = 0; end
        else if (!m_mute) begin
          if (fade_up && !fade_dn && m_pos < 127) m_pos++;
          else if (fade_dn && !fade_up && m_pos > 0) m_pos--;
        end
      end
      if (mute_cmd) begin m_ramp = 1; m_mute = 1; end
      else if (full_cmd) begin m_ramp = 2; m_mute = 0; end
      m_kill = kn;
    end
  end

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      check(out_vld == m_vld, "out_vld", out_vld, m_vld);
      check(int'($signed(out_l)) == m_ol, "out_l", int'($signed(out_l)), m_ol);
      check(int'($signed(out_r)) == m_or, "out_r", int'($signed(out_r)), m_or);
      check(int'(peak_l) == m_pl, "peak_l", peak_l, m_pl);
      check(int'(peak_r) == m_pr, "peak_r", peak_r, m_pr);
      check(kill_n == m_kill, "kill_n", kill_n, m_kill);
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  logic [31:0] lfsr = 32'hACE1_1234;
  task automatic send(int l, int r);
    smp_vld = 1; in_l = 16'(l); in_r = 16'(r);
    @(negedge clk);
    smp_vld = 0;
    @(negedge clk);
  endtask
  task automatic send_rand(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(int'($signed(lfsr[15:0])), int'($signed(lfsr[31:16])));
    end
  endtask
  task automatic pulse_mute(); mute_cmd = 1; @(negedge clk); mute_cmd = 0; @(negedge clk); endtask
  task automatic pulse_full(); full_cmd = 1; @(negedge clk); full_cmd = 0; @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(kill_n == 1 && out_vld == 0 && peak_l == 0, "reset outputs", {kill_n, out_vld}, 2);
    rst = 0;
    @(negedge clk);
    cur_req = "R2"; send_rand(40);
    send(32767, -32768); send(-1, 1);
    cur_req = "R3";
    send_rand(3); repeat (3) @(negedge clk);
    check(out_vld == 0, "R3 idle out_vld", out_vld, 0);
    cur_req = "R7"; atten_en = 1; send_rand(20); send(-32768, 32767); atten_en = 0;
    cur_req = "R8"; mono_sel = 1; send_rand(10); mono_sel = 2; send_rand(10);
    mono_sel = 3; send_rand(5); mono_sel = 0;
    cur_req = "R6"; fade_dn = 1; send_rand(30); fade_dn = 0;
    fade_up = 1; send_rand(40); fade_up = 0;
    fade_up = 1; fade_dn = 1; send_rand(5); fade_up = 0; fade_dn = 0;
    fade_dn = 1; send_rand(140); fade_dn = 0;
    send(20000, -20000);
    fade_up = 1; send_rand(140); fade_up = 0;
    cur_req = "R4"; pulse_mute(); send_rand(130);
    send(30000, -30000);
    check(out_l == 0 && out_r == 0, "R4 muted output", out_l, 0);
    cur_req = "R12"; check(kill_n == 0, "R12 kill while muted", kill_n, 0);
    cur_req = "R6"; fade_up = 1; send_rand(5); fade_up = 0;
    cur_req = "R5"; pulse_full(); send_rand(60);
    pulse_mute(); send_rand(10);
    mute_cmd = 1; full_cmd = 1; @(negedge clk); mute_cmd = 0; full_cmd = 0;
    send_rand(5);
    pulse_full(); send_rand(135);
    send(12345, -12345);
    check(out_l == 16'd12345, "R5 unity restored", out_l, 12345);
    cur_req = "R10"; peak_clr = 1; @(negedge clk); peak_clr = 0; @(negedge clk);
    check(peak_l == 0 && peak_r == 0, "R10 peaks cleared", peak_l, 0);
    cur_req = "R9"; send(1000, -300); send(-32768, 200); send(500, 32767);
    check(peak_l == 8'hFF && peak_r == 8'hFF, "R9 peak full", peak_l, 255);
    cur_req = "R10"; peak_clr = 1; smp_vld = 1; in_l = 16'h7FFF; in_r = 16'h7FFF;
    @(negedge clk); peak_clr = 0; smp_vld = 0; @(negedge clk);
    check(peak_l == 0, "R10 clear beats sample", peak_l, 0);
    cur_req = "R11"; for (int i = 0; i < TERM - 1; i++) send(0, 0);
    check(kill_n == 1, "R11 before threshold", kill_n, 1);
    send(0, 0); @(negedge clk);
    check(kill_n == 0, "R11 silence kill", kill_n, 0);
    send(0, 1); @(negedge clk);
    check(kill_n == 1, "R11 restart", kill_n, 1);
    for (int i = 0; i < TERM - 1; i++) send(0, 0);
    send(-1, 0);
    for (int i = 0; i < 10; i++) send(0, 0);
    cur_req = "R12"; cdrom_mode = 1; @(negedge clk); @(negedge clk);
    check(kill_n == 0, "R12 cdrom kill", kill_n, 0);
    cdrom_mode = 0; send_rand(4); @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule